// File: doc/BRIEF.md
# Prefetch Instruction Queue Controller

This block keeps a short queue of 16-bit program words ready for an instruction decoder. The queue has a head word, a next word and a holding slot behind them. A fetch controller issues read requests to program memory. It tracks how many words are stored and how many reads are still in flight, so the three slots can never overflow. When the decoder consumes the head, every word moves up one place and a new sequential read starts.

A redirect gives the block a new program address. The block discards everything it holds, including data from reads already in flight, and fetches three consecutive words from the new address. Two of them fill the head and next positions. The third waits in the holding slot until the first advance of the following instruction.

For a conditional branch, the decoder can launch one read at the branch target before the condition is known. The returned word goes to a side register and not into the queue. A taken outcome makes that word the new head and fetches the two words after it. A not-taken outcome advances the queue and drops the side word, and sequential fetching carries on. Program memory must return data exactly one cycle after a request.

Top module: `pfq_top`

## Requirements
- R1: While reset is high, and in the first cycle after, head_valid, next_valid and mem_req are 0. Afterwards the block fetches sequentially from the RESET_ADDR parameter (default 0), so head and next hold the words at addresses 0 and 2.
- R2: Let a redirect be sampled at clock edge k. mem_req is then 1 after edges k+1, k+2 and k+3, with mem_addr equal to T, T+2 and T+4. Here T is redir_addr with bit 0 cleared, and mem_addr bit 0 is always 0. Additions wrap modulo 2^AW.
- R3: After edge k, head_valid and next_valid are 0. Data returned for any request issued before the redirect never enters the queue.
- R4: The word at T is at the head (head_valid=1) after edge k+3. next_valid stays 0 there and becomes 1 with the word at T+2 after edge k+4.
- R5: The word at T+4 waits in the holding slot. The first advance after that gives head = word(T+2) and next = word(T+4) right after the advancing edge.
- R6: An advance sampled while head_valid is 0 has no effect: the redirect words still appear as stated in R4.
- R7: spec_go sampled at edge s (with no redirect or resolve) makes mem_req 1 with mem_addr equal to spec_addr with bit 0 cleared (S), right after edge s. The queue contents are left unchanged.
- R8: A taken resolve sampled at edge r, at least three cycles after spec_go, puts word(S) at the head with next_valid 0. Exactly two requests follow, at S+2 and S+4, after edges r+1 and r+2. word(S+2) is at next after edge r+3, and word(S+4) is held for the next advance.
- R9: A not-taken resolve sampled at edge r advances the queue by one place and discards the speculative word. The next sequential request is visible after edge r+1.
- R10: A sequential request is issued only while stored words plus outstanding sequential reads number fewer than three. With no advance, exactly three words are fetched after a redirect.
- R11: next_valid is never 1 while head_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | output | 1 | Program memory read request (registered) |
| mem_addr | output | AW | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data valid, one cycle after a request |
| mem_rdata | input | DW | Read data word |
| adv | input | 1 | Decoder consumes the head word |
| redir | input | 1 | Change of flow: flush and fetch from redir_addr |
| redir_addr | input | AW | New program address |
| spec_go | input | 1 | Launch one speculative fetch at spec_addr |
| spec_addr | input | AW | Branch target address |
| res_go | input | 1 | Branch outcome is valid this cycle |
| res_taken | input | 1 | 1 = taken, 0 = not taken |
| head_word | output | DW | Oldest queued word |
| head_valid | output | 1 | head_word holds a word |
| next_word | output | DW | Second queued word |
| next_valid | output | 1 | next_word holds a word |

## Verification
Each result has a fixed due cycle, counted from the edge that samples the control input. A redirect shows its three requests after edges k+1 to k+3, its head word after k+3 and its next word after k+4. A speculative request shows right after its own edge. A taken head word shows after r, with its two refill requests after r+1 and r+2. The bench drives inputs on the falling edge and counts rising edges one by one, sampling each output half a cycle after the edge that makes it due. A running request counter checks the exact number of fetches. Stale or speculative data is detected because every memory word carries its own address.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  // what the registered request currently on the memory port is for
  typedef enum logic [1:0] {
    REQ_IDLE = 2'd0,
    REQ_SEQ  = 2'd1,
    REQ_SPEC = 2'd2
  } req_kind_e;

  localparam int WORD_BYTES = 2;
endpackage

// File: rtl/pfq_slots.sv
// Ordered word store: slot 0 = head, slot 1 = next, remaining = holding.
module pfq_slots #(
  parameter int DW = 16,
  parameter int N  = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     flush,
  input  logic                     load_en,
  input  logic [DW-1:0]            load_word,
  input  logic                     shift_req,
  input  logic                     wr_en,
  input  logic [DW-1:0]            wr_word,
  output logic [DW-1:0]            head_word,
  output logic                     head_valid,
  output logic [DW-1:0]            next_word,
  output logic                     next_valid,
  output logic [$clog2(N+1)-1:0]   fill
);
  localparam int CW = $clog2(N+1);

  logic [N-1:0]  v_q, sv, put, nv;
  logic [DW-1:0] d_q [N];
  logic [DW-1:0] sd  [N];
  logic [DW-1:0] nd  [N];
  logic          shift;

  assign shift = shift_req & v_q[0];

  for (genvar g = 0; g < N; g++) begin : g_slot
    if (g < N-1) begin : g_mid
      assign sv[g] = shift ? v_q[g+1] : v_q[g];
      assign sd[g] = shift ? d_q[g+1] : d_q[g];
    end else begin : g_tail
      assign sv[g] = shift ? 1'b0 : v_q[g];
      assign sd[g] = d_q[g];
    end
    if (g == 0) begin : g_first
      assign put[g] = wr_en & ~sv[g];
    end else begin : g_rest
      assign put[g] = wr_en & ~sv[g] & sv[g-1];
    end
    assign nv[g] = sv[g] | put[g];
    assign nd[g] = put[g] ? wr_word : sd[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= '0;
      for (int i = 0; i < N; i++) d_q[i] <= '0;
    end else if (flush) begin
      v_q    <= {{(N-1){1'b0}}, load_en};
      d_q[0] <= load_word;
    end else begin
      v_q <= nv;
      for (int i = 0; i < N; i++) d_q[i] <= nd[i];
    end
  end

  assign head_word  = d_q[0];
  assign head_valid = v_q[0];
  assign next_word  = d_q[1];
  assign next_valid = v_q[1];
  assign fill       = CW'($countones(v_q));
endmodule

// File: rtl/pfq_spec.sv
// Side register for the speculative target word and its address.
module pfq_spec #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic [AW-1:0] arm_addr,
  input  logic          cap,
  input  logic [DW-1:0] cap_word,
  output logic [AW-1:0] tgt,
  output logic [DW-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tgt  <= '0;
      word <= '0;
    end else begin
      if (arm) tgt  <= arm_addr;
      if (cap) word <= cap_word;
    end
  end
endmodule

// File: rtl/pfq_fetch.sv
// Request sequencer: sequential refill, redirect restart, speculative launch.
module pfq_fetch
  import pfq_pkg::*;
#(
  parameter int           AW         = 16,
  parameter int           SLOTS      = 3,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        redir,
  input  logic [AW-1:0]               redir_tgt,
  input  logic                        take,
  input  logic [AW-1:0]               take_tgt,
  input  logic                        arm,
  input  logic [AW-1:0]               arm_addr,
  input  logic [$clog2(SLOTS+1)-1:0]  fill,
  input  logic                        rvalid,
  output logic                        mem_req,
  output logic [AW-1:0]               mem_addr,
  output logic                        seq_wr,
  output logic                        spec_cap
);
  localparam int            OW   = $clog2(SLOTS+3);
  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  req_kind_e     kind_q;
  logic [AW-1:0] fetch_q, addr_q;
  logic          pend_spec_q, pend_kill_q;
  logic [OW-1:0] owed;
  logic          issue;

  assign seq_wr   = rvalid & ~pend_spec_q & ~pend_kill_q;
  assign spec_cap = rvalid &  pend_spec_q & ~pend_kill_q;
  assign owed     = OW'(fill) + OW'(kind_q == REQ_SEQ) + OW'(seq_wr);
  assign issue    = owed < OW'(SLOTS);

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q      <= REQ_IDLE;
      fetch_q     <= RESET_ADDR & ~AW'(1);
      addr_q      <= '0;
      pend_spec_q <= 1'b0;
      pend_kill_q <= 1'b0;
    end else begin
      pend_spec_q <= (kind_q == REQ_SPEC);
      pend_kill_q <= (kind_q != REQ_IDLE) & (redir | take);
      if (redir) begin
        fetch_q <= redir_tgt;
        kind_q  <= REQ_IDLE;
      end else if (take) begin
        fetch_q <= take_tgt + STEP;
        kind_q  <= REQ_IDLE;
      end else if (arm) begin
        kind_q <= REQ_SPEC;
        addr_q <= arm_addr;
      end else if (issue) begin
        kind_q  <= REQ_SEQ;
        addr_q  <= fetch_q;
        fetch_q <= fetch_q + STEP;
      end else begin
        kind_q <= REQ_IDLE;
      end
    end
  end

  assign mem_req  = (kind_q != REQ_IDLE);
  assign mem_addr = addr_q;
endmodule

// File: rtl/pfq_top.sv
module pfq_top #(
  parameter int            AW         = 16,
  parameter int            DW         = 16,
  parameter int            SLOTS      = 3,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  input  logic          adv,
  input  logic          redir,
  input  logic [AW-1:0] redir_addr,
  input  logic          spec_go,
  input  logic [AW-1:0] spec_addr,
  input  logic          res_go,
  input  logic          res_taken,
  output logic [DW-1:0] head_word,
  output logic          head_valid,
  output logic [DW-1:0] next_word,
  output logic          next_valid
);
  localparam int CW = $clog2(SLOTS+1);

  logic          take, skip, arm, seq_wr, spec_cap;
  logic [AW-1:0] redir_al, spec_al, spec_tgt;
  logic [DW-1:0] spec_word;
  logic [CW-1:0] fill;

  assign redir_al = redir_addr & ~AW'(1);
  assign spec_al  = spec_addr  & ~AW'(1);
  assign take     = res_go &  res_taken & ~redir;
  assign skip     = res_go & ~res_taken & ~redir;
  assign arm      = spec_go & ~redir & ~res_go;

  pfq_fetch #(.AW(AW), .SLOTS(SLOTS), .RESET_ADDR(RESET_ADDR)) u_fetch (
    .clk(clk), .rst(rst),
    .redir(redir), .redir_tgt(redir_al),
    .take(take), .take_tgt(spec_tgt),
    .arm(arm), .arm_addr(spec_al),
    .fill(fill), .rvalid(mem_rvalid),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .seq_wr(seq_wr), .spec_cap(spec_cap)
  );

  pfq_spec #(.AW(AW), .DW(DW)) u_spec (
    .clk(clk), .rst(rst),
    .arm(arm), .arm_addr(spec_al),
    .cap(spec_cap), .cap_word(mem_rdata),
    .tgt(spec_tgt), .word(spec_word)
  );

  pfq_slots #(.DW(DW), .N(SLOTS)) u_slots (
    .clk(clk), .rst(rst),
    .flush(redir | take), .load_en(take), .load_word(spec_word),
    .shift_req(adv | skip),
    .wr_en(seq_wr), .wr_word(mem_rdata),
    .head_word(head_word), .head_valid(head_valid),
    .next_word(next_word), .next_valid(next_valid),
    .fill(fill)
  );
endmodule

// File: rtl/pfq_chk.sv
module pfq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          redir,
  input logic [AW-1:0] redir_addr,
  input logic          spec_go,
  input logic [AW-1:0] spec_addr,
  input logic          res_go,
  input logic          res_taken,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          head_valid,
  input logic          next_valid
);
  localparam logic [AW-1:0] ALIGN = ~AW'(1);

  logic       rst_q = 1'b0;
  logic [1:0] since_rst = 2'd0;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R1: outputs quiet in the cycle after a reset edge
  always @(posedge clk) begin
    if (rst_q) begin
      assert_reset_quiet_R1: assert (!mem_req && !head_valid && !next_valid);
    end
  end

  assert_redir_fetch_R2: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2 && $past(redir, 2) && !$past(redir) && !$past(res_go) && !$past(spec_go))
      |-> (mem_req && mem_addr == ($past(redir_addr, 2) & ALIGN)));

  assert_word_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !mem_addr[0]);

  assert_redir_flush_R3: assert property (@(posedge clk) disable iff (rst)
    redir |=> (!head_valid && !next_valid && !mem_req));

  assert_spec_launch_R7: assert property (@(posedge clk) disable iff (rst)
    (spec_go && !redir && !res_go) |=> (mem_req && mem_addr == ($past(spec_addr) & ALIGN)));

  assert_taken_head_R8: assert property (@(posedge clk) disable iff (rst)
    (res_go && res_taken && !redir) |=> (head_valid && !next_valid));

  assert_order_R11: assert property (@(posedge clk) disable iff (rst)
    next_valid |-> head_valid);
endmodule

bind pfq_top pfq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst),
  .redir(redir), .redir_addr(redir_addr),
  .spec_go(spec_go), .spec_addr(spec_addr),
  .res_go(res_go), .res_taken(res_taken),
  .mem_req(mem_req), .mem_addr(mem_addr),
  .head_valid(head_valid), .next_valid(next_valid)
);

// File: tb/sim_pfq_top.sv
`timescale 1ns/1ps
module sim_pfq_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_req, mem_rvalid;
  logic [15:0] mem_addr, mem_rdata;
  logic        adv = 0, redir = 0, spec_go = 0, res_go = 0, res_taken = 0;
  logic [15:0] redir_addr = '0, spec_addr = '0;
  logic [15:0] head_word, next_word;
  logic        head_valid, next_valid;

  int total = 0;
  int bad   = 0;
  int req_cnt = 0;

  always #2 clk = ~clk;

  pfq_top u0 (
    .clk(clk), .rst(rst),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .adv(adv), .redir(redir), .redir_addr(redir_addr),
    .spec_go(spec_go), .spec_addr(spec_addr),
    .res_go(res_go), .res_taken(res_taken),
    .head_word(head_word), .head_valid(head_valid),
    .next_word(next_word), .next_valid(next_valid)
  );

  // program memory: one cycle latency, word tagged by its address
  function automatic logic [15:0] wf(input logic [15:0] a);
    return a ^ 16'h5A00;
  endfunction

  always @(posedge clk) begin
    mem_rvalid <= mem_req & ~rst;
    mem_rdata  <= wf(mem_addr);
    if (mem_req) req_cnt <= req_cnt + 1;
  end

  // {raw redirect address, expected first word}
  localparam logic [31:0] VEC [4] = '{
    32'h0100_5B00, 32'h2469_7E68, 32'hFFFA_A5FA, 32'h0000_5A00
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic jump_settle(input logic [15:0] a);
    redir = 1; redir_addr = a;
    tick();
    redir = 0;
    repeat (7) tick();
  endtask

  task automatic redirect_vec(input logic [15:0] raw, input logic [15:0] exp0);
    logic [15:0] t;
    t = raw & 16'hFFFE;
    req_cnt = 0; redir = 1; redir_addr = raw;
    tick();
    redir = 0;
    chk("R3 head_valid after redirect", 32'(head_valid), 0);
    chk("R3 next_valid after redirect", 32'(next_valid), 0);
    tick();
    chk("R2 first request", {15'd0, mem_req, mem_addr}, {15'd0, 1'b1, t});
    tick();
    chk("R2 second request", {15'd0, mem_req, mem_addr}, {15'd0, 1'b1, 16'(t + 16'd2)});
    tick();
    chk("R2 third request", {15'd0, mem_req, mem_addr}, {15'd0, 1'b1, 16'(t + 16'd4)});
    chk("R4 head word", {15'd0, head_valid, head_word}, {15'd0, 1'b1, exp0});
    chk("R4 next not yet", 32'(next_valid), 0);
    tick();
    chk("R4 next word", {15'd0, next_valid, next_word}, {15'd0, 1'b1, wf(t + 16'd2)});
    tick(); tick();
    chk("R10 fetch count after redirect", 32'(req_cnt), 3);
    adv = 1;
    tick();
    adv = 0;
    chk("R5 head after advance", 32'(head_word), 32'(wf(t + 16'd2)));
    chk("R5 next from holding slot", {15'd0, next_valid, next_word}, {15'd0, 1'b1, wf(t + 16'd4)});
    repeat (5) tick();
  endtask

  initial begin
    #80000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    repeat (3) tick();
    chk("R1 head_valid in reset", 32'(head_valid), 0);
    chk("R1 mem_req in reset", 32'(mem_req), 0);
    rst = 0;
    repeat (8) tick();
    chk("R1 head from reset address", {15'd0, head_valid, head_word}, {15'd0, 1'b1, wf(16'h0000)});
    chk("R1 next from reset address", {15'd0, next_valid, next_word}, {15'd0, 1'b1, wf(16'h0002)});

    for (int i = 0; i < 4; i++) redirect_vec(VEC[i][31:16], VEC[i][15:0]);

    // R6: advance while the head is empty
    redir = 1; redir_addr = 16'h4000;
    tick();
    redir = 0; adv = 1;
    repeat (3) tick();
    adv = 0;
    chk("R6 head unaffected by early advance", {15'd0, head_valid, head_word}, {15'd0, 1'b1, wf(16'h4000)});
    tick();
    chk("R6 next unaffected by early advance", 32'(next_word), 32'(wf(16'h4002)));
    repeat (4) tick();

    // R3: a read in flight at the redirect is dropped
    adv = 1;
    tick();
    adv = 0;
    tick();
    chk("R3 read in flight before redirect", 32'(mem_req), 1);
    redir = 1; redir_addr = 16'h6000;
    tick();
    redir = 0;
    tick();
    chk("R3 stale word discarded", 32'(head_valid), 0);
    tick(); tick();
    chk("R3 head after stale drop", {15'd0, head_valid, head_word}, {15'd0, 1'b1, wf(16'h6000)});
    tick();
    chk("R3 next after stale drop", 32'(next_word), 32'(wf(16'h6002)));
    repeat (3) tick();

    // R7 and R8: speculative fetch, branch taken
    spec_go = 1; spec_addr = 16'h1235;
    tick();
    spec_go = 0;
    chk("R7 speculative request", {15'd0, mem_req, mem_addr}, {15'd0, 1'b1, 16'h1234});
    tick(); tick();
    chk("R7 queue untouched", {head_word, next_word}, {wf(16'h6000), wf(16'h6002)});
    res_go = 1; res_taken = 1; req_cnt = 0;
    tick();
    res_go = 0; res_taken = 0;
    chk("R8 target word at head", {15'd0, head_valid, head_word}, {15'd0, 1'b1, wf(16'h1234)});
    chk("R8 next empty after taken", 32'(next_valid), 0);
    tick();
    chk("R8 refill request 1", {15'd0, mem_req, mem_addr}, {15'd0, 1'b1, 16'h1236});
    tick();
    chk("R8 refill request 2", {15'd0, mem_req, mem_addr}, {15'd0, 1'b1, 16'h1238});
    tick();
    chk("R8 next after taken", {15'd0, next_valid, next_word}, {15'd0, 1'b1, wf(16'h1236)});
    tick(); tick();
    chk("R8 two fetches after taken", 32'(req_cnt), 2);
    adv = 1;
    tick();
    adv = 0;
    chk("R8 held word after advance", {head_word, next_word}, {wf(16'h1236), wf(16'h1238)});
    repeat (5) tick();

    // R9: speculative fetch, branch not taken
    jump_settle(16'h0800);
    spec_go = 1; spec_addr = 16'h3000;
    tick();
    spec_go = 0;
    tick(); tick();
    res_go = 1; res_taken = 0;
    tick();
    res_go = 0;
    chk("R9 queue advanced", {head_word, next_word}, {wf(16'h0802), wf(16'h0804)});
    tick();
    chk("R9 sequential refill", {15'd0, mem_req, mem_addr}, {15'd0, 1'b1, 16'h0806});
    repeat (3) tick();
    adv = 1;
    tick();
    adv = 0;
    chk("R9 speculative word not queued", {head_word, next_word}, {wf(16'h0804), wf(16'h0806)});
    chk("R11 order of valid flags", {30'd0, head_valid, next_valid}, 32'd3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule